// File: doc/BRIEF.md
# Synchronous Burst Read Sequencer

This block is the device-side control of a synchronous burst read from a word-addressed memory array. A host loads a configuration word, then opens a read by pulsing an address-valid strobe together with a start word address. The sequencer counts an initial latency, then drives the array one word address per clock. A ready output marks when each data word is available. The array that answers these addresses sits outside the block.

The latency comes from a 3-bit code that a configuration write takes from bits 14 to 12 of the configuration address. The block adds one cycle when the start address is odd, and two more when a linear burst starts in the last two words of a 64-word group, because it then crosses a group boundary. Bursts run either linearly over the whole address space or as 8-, 16- or 32-word wrap-around loops that stay inside their aligned group. A burst ends when the chip select drops or when a new strobe starts another access.

Top module: `burst_rd_seq`

## Requirements
- R1: After reset `arr_rd_en` and `rdy` are low, the latency code is 101 (7 cycles) and the burst mode is linear.
- R2: A configuration write (`cfg_we` high at a clock edge) loads the latency code from `cfg_addr[14:12]` and the burst mode from `cfg_addr[1:0]`. Codes 000 to 101 give a base latency of 2 to 7 cycles. Modes are 00 linear, 01 wrap-8, 10 wrap-16 and 11 wrap-32.
- R3: A configuration write with code 110 or 111 changes neither the latency nor the mode.
- R4: Call the edge that samples `addr_valid` high with `chip_sel` high edge 0. After edge T, `arr_rd_en` is high and `arr_addr` equals the start address. T is the base latency, plus 1 for an odd start address, plus 2 when R5's boundary condition holds.
- R5: The boundary condition holds only in linear mode when the low six bits of the start address are 62 or 63.
- R6: From edge 0 until edge T, `arr_rd_en` stays low, and `rdy` stays low except as stated in R7.
- R7: With a base latency above 2, `rdy` rises after edge T-1, one cycle ahead of the data. With a base latency of 2, `rdy` rises together with `arr_rd_en`. During the burst `rdy` stays high with `arr_rd_en`.
- R8: In linear mode `arr_addr` increases by one at each edge and rolls from the highest address to 0.
- R9: In a wrap-N mode, the low log2(N) bits of `arr_addr` count up modulo N and the upper bits hold. The pointer never leaves its aligned 64-word group.
- R10: When an edge samples `chip_sel` low, `arr_rd_en` and `rdy` are low after that edge. A strobe is ignored while `chip_sel` is low.
- R11: A new strobe during a latency count or a burst restarts the count from that edge, and both outputs are low after it.
- R12: The latency and the mode are captured at the strobe edge. A configuration write during an access does not change that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| chip_sel | input | 1 | Chip select, active high |
| addr_valid | input | 1 | Start strobe, active high, sampled at the rising edge |
| start_addr | input | ADDR_W | First word address of the burst |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | ADDR_W | Configuration word: [14:12] latency code, [1:0] burst mode |
| arr_addr | output | ADDR_W | Word address sent to the array |
| arr_rd_en | output | 1 | Array read enable, high while data words are valid |
| rdy | output | 1 | Ready to the host |

## Verification
The strobe edge is edge 0. The bench counts the clock edges from it and compares the outputs to a table built from the latency formula. `arr_rd_en` must first be high after edge T, and `rdy` after edge T-1, or after edge T when the base latency is 2. From then on the expected address changes once per edge. All inputs are driven and all outputs read at the falling edge, so each check sees the registered result of exactly one rising edge. Stopping on chip select and restarting on a new strobe each take one edge, and the bench checks the outputs right after that edge.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    typedef enum logic [1:0] {
        BM_LINEAR = 2'b00,
        BM_WRAP8  = 2'b01,
        BM_WRAP16 = 2'b10,
        BM_WRAP32 = 2'b11
    } burst_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_BEAT
    } seq_state_e;

    localparam int LAT_W      = 4;
    localparam int CODE_W     = 3;
    localparam logic [CODE_W-1:0] CODE_DEFAULT = 3'b101;
    localparam logic [CODE_W-1:0] CODE_MAX     = 3'b101;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        burst_mode_e       mode;
    } seq_cfg_t;

endpackage

// File: rtl/burst_cfg_regs.sv
module burst_cfg_regs
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int CODE_LSB = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    output logic [CODE_W-1:0] wait_code,
    output burst_mode_e       mode
);

    localparam int CODE_MSB = CODE_LSB + CODE_W - 1;

    seq_cfg_t cfg_d, cfg_q;
    logic [CODE_W-1:0] code_in;
    logic unused_cfg_bits;

    assign code_in = cfg_addr[CODE_MSB:CODE_LSB];
    assign unused_cfg_bits = ^{cfg_addr[ADDR_W-1:CODE_MSB+1], cfg_addr[CODE_LSB-1:2]};

    // Reserved codes (above CODE_MAX) drop the whole write.
    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we && (code_in <= CODE_MAX)) begin
            cfg_d.code = code_in;
            cfg_d.mode = burst_mode_e'(cfg_addr[1:0]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.code <= CODE_DEFAULT;
            cfg_q.mode <= BM_LINEAR;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign wait_code = cfg_q.code;
    assign mode      = cfg_q.mode;

    AST_RESV_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && (code_in > CODE_MAX)) |=> ($stable(cfg_q.code) && $stable(cfg_q.mode))); // R3

endmodule

// File: rtl/burst_latency_calc.sv
module burst_latency_calc
    import burst_seq_pkg::*;
#(
    parameter int GROUP_LG = 6
) (
    input  logic [CODE_W-1:0]   wait_code,
    input  burst_mode_e         mode,
    input  logic [GROUP_LG-1:0] start_lo,
    output logic [LAT_W-1:0]    lat_total,
    output logic                lat_early
);

    localparam logic [LAT_W-1:0] BASE_OFS = LAT_W'(2);

    logic odd_start;
    logic at_boundary;

    always_comb begin
        odd_start   = start_lo[0];
        // Last two words of an aligned group; only linear bursts cross it.
        at_boundary = (mode == BM_LINEAR) && (&start_lo[GROUP_LG-1:1]);
        lat_total   = LAT_W'(wait_code) + BASE_OFS
                    + LAT_W'(odd_start) + LAT_W'({at_boundary, 1'b0});
        // Ready leads data by a cycle unless the base setting is the minimum.
        lat_early   = (wait_code != '0);
    end

endmodule

// File: rtl/burst_addr_step.sv
module burst_addr_step
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  burst_mode_e       mode,
    output logic [ADDR_W-1:0] nxt_addr
);

    logic [7:0]        span_lg;
    logic [ADDR_W-1:0] step_mask;
    logic [ADDR_W-1:0] inc_addr;

    always_comb begin
        case (mode)
            BM_WRAP8:  span_lg = 8'd3;
            BM_WRAP16: span_lg = 8'd4;
            BM_WRAP32: span_lg = 8'd5;
            default:   span_lg = 8'(ADDR_W);
        endcase
    end

    for (genvar i = 0; i < ADDR_W; i++) begin : g_mask
        assign step_mask[i] = (8'(i) < span_lg);
    end

    assign inc_addr = cur_addr + ADDR_W'(1);
    assign nxt_addr = (cur_addr & ~step_mask) | (inc_addr & step_mask);

endmodule

// File: rtl/burst_rd_seq.sv
module burst_rd_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int GROUP_LG = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chip_sel,
    input  logic              addr_valid,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    output logic [ADDR_W-1:0] arr_addr,
    output logic              arr_rd_en,
    output logic              rdy
);

    typedef struct packed {
        seq_state_e        state;
        logic [LAT_W-1:0]  cnt;
        logic              early;
        burst_mode_e       mode;
        logic [ADDR_W-1:0] addr;
        logic              rdy;
        logic              rd_en;
    } seq_t;

    seq_t s_d, s_q;

    logic [CODE_W-1:0] wait_code;
    burst_mode_e       cfg_mode;
    logic [LAT_W-1:0]  lat_total;
    logic              lat_early;
    logic [ADDR_W-1:0] step_addr;

    burst_cfg_regs #(.ADDR_W(ADDR_W), .CODE_LSB(12)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .wait_code (wait_code),
        .mode      (cfg_mode)
    );

    burst_latency_calc #(.GROUP_LG(GROUP_LG)) u_lat (
        .wait_code (wait_code),
        .mode      (cfg_mode),
        .start_lo  (start_addr[GROUP_LG-1:0]),
        .lat_total (lat_total),
        .lat_early (lat_early)
    );

    burst_addr_step #(.ADDR_W(ADDR_W)) u_step (
        .cur_addr (s_q.addr),
        .mode     (s_q.mode),
        .nxt_addr (step_addr)
    );

    always_comb begin
        s_d = s_q;
        if (!chip_sel) begin
            s_d.state = ST_IDLE;
            s_d.rdy   = 1'b0;
            s_d.rd_en = 1'b0;
        end else if (addr_valid) begin
            s_d.state = ST_WAIT;
            s_d.cnt   = lat_total;
            s_d.early = lat_early;
            s_d.mode  = cfg_mode;
            s_d.addr  = start_addr;
            s_d.rdy   = 1'b0;
            s_d.rd_en = 1'b0;
        end else begin
            case (s_q.state)
                ST_WAIT: begin
                    if (s_q.cnt == LAT_W'(1)) begin
                        s_d.state = ST_BEAT;
                        s_d.rd_en = 1'b1;
                        s_d.rdy   = 1'b1;
                    end else begin
                        s_d.cnt = s_q.cnt - LAT_W'(1);
                        if ((s_q.cnt == LAT_W'(2)) && s_q.early) begin
                            s_d.rdy = 1'b1;
                        end
                    end
                end
                ST_BEAT: begin
                    s_d.addr = step_addr;
                end
                default: begin
                    s_d.rdy   = 1'b0;
                    s_d.rd_en = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.state <= ST_IDLE;
            s_q.cnt   <= '0;
            s_q.early <= 1'b0;
            s_q.mode  <= BM_LINEAR;
            s_q.addr  <= '0;
            s_q.rdy   <= 1'b0;
            s_q.rd_en <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign arr_addr  = s_q.addr;
    assign arr_rd_en = s_q.rd_en;
    assign rdy       = s_q.rdy;

    AST_CS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        !chip_sel |=> (!arr_rd_en && !rdy)); // R10

    AST_STROBE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_sel && addr_valid) |=> (!arr_rd_en && !rdy && (arr_addr == $past(start_addr)))); // R11

    AST_WAIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == ST_WAIT) |-> !arr_rd_en); // R6

    AST_RDY_WITH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        arr_rd_en |-> rdy); // R7

    AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_sel && !addr_valid && arr_rd_en && (s_q.mode == BM_LINEAR))
        |=> (arr_addr == ($past(arr_addr) + ADDR_W'(1)))); // R8

    AST_WRAP_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_sel && !addr_valid && arr_rd_en && (s_q.mode != BM_LINEAR))
        |=> (arr_addr[ADDR_W-1:GROUP_LG] == $past(arr_addr[ADDR_W-1:GROUP_LG]))); // R9

endmodule

// File: tb/burst_rd_seq_tb_top.sv
module burst_rd_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          chip_sel = 1'b0;
    logic          addr_valid = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic          cfg_we = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic [AW-1:0] arr_addr;
    logic          arr_rd_en;
    logic          rdy;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_rd_seq #(.ADDR_W(AW), .GROUP_LG(6)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .chip_sel   (chip_sel),
        .addr_valid (addr_valid),
        .start_addr (start_addr),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .arr_addr   (arr_addr),
        .arr_rd_en  (arr_rd_en),
        .rdy        (rdy)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] s, input logic [1:0] m, input int i);
        logic [AW-1:0] n;
        if (m == 2'b00) return AW'(s + AW'(i));
        n = AW'(8) << (m - 2'd1);
        return (s & ~(n - AW'(1))) | (AW'(s + AW'(i)) & (n - AW'(1)));
    endfunction

    task automatic cfg_write(input logic [2:0] code, input logic [1:0] mode);
        @(negedge clk);
        cfg_we   = 1'b1;
        cfg_addr = '0;
        cfg_addr[14:12] = code;
        cfg_addr[1:0]   = mode;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Strobe at edge 0, then check every edge up to T+beats-1.
    task automatic run_burst(input string req, input logic [AW-1:0] s, input int t,
                             input bit early, input logic [1:0] m, input int beats,
                             input bit mid_cfg, input logic [2:0] mc, input logic [1:0] mm);
        @(negedge clk);
        chip_sel   = 1'b1;
        addr_valid = 1'b1;
        start_addr = s;
        @(posedge clk);
        for (int k = 0; k < t + beats; k++) begin
            bit e_en;
            bit e_rdy;
            @(negedge clk);
            addr_valid = 1'b0;
            start_addr = ~s;
            if (mid_cfg && k == 0) begin
                cfg_we = 1'b1;
                cfg_addr = '0;
                cfg_addr[14:12] = mc;
                cfg_addr[1:0]   = mm;
            end else begin
                cfg_we = 1'b0;
            end
            e_en  = (k >= t);
            e_rdy = e_en || (early && (k == t - 1));
            chk($sformatf("%s rd_en s=%0h k=%0d", req, s, k), 32'(arr_rd_en), 32'(e_en));
            chk($sformatf("%s rdy s=%0h k=%0d", req, s, k), 32'(rdy), 32'(e_rdy));
            if (e_en)
                chk($sformatf("%s addr s=%0h k=%0d", req, s, k), 32'(arr_addr), 32'(exp_addr(s, m, k - t)));
        end
    endtask

    task automatic end_burst(input string req);
        @(negedge clk);
        chip_sel = 1'b0;
        @(negedge clk);
        chk({req, " R10 stop rd_en"}, 32'(arr_rd_en), 32'd0);
        chk({req, " R10 stop rdy"}, 32'(rdy), 32'd0);
    endtask

    task automatic t_reset;
        chk("R1 reset rd_en", 32'(arr_rd_en), 32'd0);
        chk("R1 reset rdy", 32'(rdy), 32'd0);
        run_burst("R1 default", 16'h0010, 7, 1'b1, 2'b00, 3, 1'b0, 3'd0, 2'd0);
        end_burst("R1");
    endtask

    task automatic t_codes;
        for (int c = 0; c < 6; c++) begin
            cfg_write(3'(c), 2'b00);
            run_burst("R2 R4 R7 code", 16'h0100, c + 2, c != 0, 2'b00, 4, 1'b0, 3'd0, 2'd0);
            end_burst("R2");
        end
    endtask

    task automatic t_odd_boundary;
        cfg_write(3'd2, 2'b00);
        run_burst("R4 odd", 16'h0101, 5, 1'b1, 2'b00, 3, 1'b0, 3'd0, 2'd0);
        end_burst("R4");
        cfg_write(3'd1, 2'b00);
        run_burst("R5 even bnd", 16'h003E, 5, 1'b1, 2'b00, 4, 1'b0, 3'd0, 2'd0);
        end_burst("R5");
        run_burst("R5 odd bnd", 16'h003F, 6, 1'b1, 2'b00, 3, 1'b0, 3'd0, 2'd0);
        end_burst("R5");
        run_burst("R5 odd no bnd", 16'h013D, 4, 1'b1, 2'b00, 3, 1'b0, 3'd0, 2'd0);
        end_burst("R5");
        run_burst("R8 rollover", 16'hFFFE, 5, 1'b1, 2'b00, 4, 1'b0, 3'd0, 2'd0);
        end_burst("R8");
    endtask

    task automatic t_wrap;
        cfg_write(3'd0, 2'b01);
        run_burst("R9 wrap8", 16'h0045, 3, 1'b0, 2'b01, 10, 1'b0, 3'd0, 2'd0);
        end_burst("R9");
        cfg_write(3'd0, 2'b10);
        run_burst("R9 wrap16", 16'h003E, 2, 1'b0, 2'b10, 18, 1'b0, 3'd0, 2'd0);
        end_burst("R9");
        cfg_write(3'd0, 2'b11);
        run_burst("R9 wrap32", 16'h007D, 3, 1'b0, 2'b11, 34, 1'b0, 3'd0, 2'd0);
        end_burst("R9");
    endtask

    task automatic t_reserved;
        cfg_write(3'd3, 2'b00);
        cfg_write(3'd6, 2'b10);
        run_burst("R3 code110", 16'h0200, 5, 1'b1, 2'b00, 20, 1'b0, 3'd0, 2'd0);
        end_burst("R3");
        cfg_write(3'd7, 2'b11);
        run_burst("R3 code111", 16'h021E, 5, 1'b1, 2'b00, 36, 1'b0, 3'd0, 2'd0);
        end_burst("R3");
    endtask

    task automatic t_cs_ignore;
        @(negedge clk);
        chip_sel   = 1'b0;
        addr_valid = 1'b1;
        start_addr = 16'h0300;
        @(negedge clk);
        addr_valid = 1'b0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            chk("R10 strobe ignored rd_en", 32'(arr_rd_en), 32'd0);
            chk("R10 strobe ignored rdy", 32'(rdy), 32'd0);
        end
    endtask

    task automatic t_restart;
        cfg_write(3'd3, 2'b00);
        run_burst("R11 first", 16'h0300, 5, 1'b1, 2'b00, 2, 1'b0, 3'd0, 2'd0);
        run_burst("R11 mid-burst", 16'h0400, 5, 1'b1, 2'b00, 3, 1'b0, 3'd0, 2'd0);
        @(negedge clk);
        addr_valid = 1'b1;
        start_addr = 16'h0500;
        @(negedge clk);
        addr_valid = 1'b0;
        run_burst("R11 mid-wait", 16'h0600, 5, 1'b1, 2'b00, 3, 1'b0, 3'd0, 2'd0);
        end_burst("R11");
    endtask

    task automatic t_capture;
        cfg_write(3'd1, 2'b00);
        run_burst("R12 capture", 16'h0738, 3, 1'b1, 2'b00, 10, 1'b1, 3'd5, 2'b01);
        end_burst("R12");
        run_burst("R12 new setting", 16'h0738, 7, 1'b1, 2'b01, 10, 1'b0, 3'd0, 2'd0);
        end_burst("R12");
    endtask

    task automatic t_hw_reset;
        cfg_write(3'd0, 2'b11);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset mid rd_en", 32'(arr_rd_en), 32'd0);
        rst_n = 1'b1;
        run_burst("R1 after reset", 16'h0820, 7, 1'b1, 2'b00, 40, 1'b0, 3'd0, 2'd0);
        end_burst("R1");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_codes();
        t_odd_boundary();
        t_wrap();
        t_reserved();
        t_cs_ignore();
        t_restart();
        t_capture();
        t_hw_reset();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog R1 actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule